// File: doc/BRIEF.md
# Dual Selectable Power-of-Two Clock Divider

This block derives two slower clocks, A and B, from a single input clock. Each output has its own 2-bit ratio code. Output A offers divide by 1, 2, 4 or 8. Output B offers divide by 2, 4, 8 or 16. Both outputs are tapped from one shared 4-bit down-counter. Every divided output therefore rises on the same input edge as every slower one, and the divide-by-1 path is the input clock gated by the same run condition.

A run enable, sampled on the falling edge of the input clock, freezes the counter and both outputs without cutting a phase short. An active-low master reset forces both outputs low at once. Its release is synchronized inside the block, so several dividers released together start counting on the same edge. A new ratio code is adopted only when the counter wraps, which keeps every pulse at least half of its new period wide.

Top module: `dual_clkdiv`

## Requirements
- R1: Output A ratio code `sel_a` (bit 1, bit 0): 00 = divide by 1, 01 = by 2, 10 = by 4, 11 = by 8.
- R2: Output B ratio code `sel_b` (bit 1, bit 0): 00 = divide by 2, 01 = by 4, 10 = by 8, 11 = by 16.
- R3: Let n be the number of counted rising edges since reset. A divided output of ratio D is high exactly when n >= 1 and (n-1) mod D < D/2. All outputs therefore rise together on the first counted edge of each period, and two outputs at the same ratio are identical.
- R4: In divide-by-1 mode, `div_a` equals the input clock ANDed with the run state captured at the last falling edge. It is low whenever the block is held or in reset.
- R5: `run_en` is sampled on each falling edge of `clk_in` and governs the next rising edge. While it is low, the counter does not advance and both outputs keep their level.
- R6: While `rst_n` is low, both outputs are low, immediately and regardless of the clock. The counter and the adopted ratio codes return to zero.
- R7: Reset release passes through two rising-edge synchronizer stages. The third rising edge after `rst_n` goes high is the first edge that can be counted, and both outputs rise together on it.
- R8: Ratio codes are adopted only on a counted edge that starts a new 16-edge cycle, that is, when n mod 16 = 0 before the edge. The first counted edge after reset is such an edge. At any other time a change on `sel_a` or `sel_b` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low master reset; asynchronous assertion, synchronized release |
| run_en | input | 1 | Run enable; low freezes both outputs |
| sel_a | input | 2 | Ratio code for output A |
| sel_b | input | 2 | Ratio code for output B |
| div_a | output | 1 | Divided clock A |
| div_b | output | 1 | Divided clock B |

## Verification
The hardest state to reach from the ports is a ratio change requested in the middle of a counter cycle, especially when it overlaps a hold. A request like that must stay pending until the wrap edge, so the outputs only reveal whether it was adopted up to 16 counted edges later. The stimulus holds ratio codes for random stretches and changes them at random phases. It also drops the enable in bursts so that wraps are delayed, and it adds a directed case that changes both codes at phase 5. The bench model tracks the pending codes and applies them only on the wrap edge.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned SEL_W = $clog2(CNT_W);
  typedef logic [SEL_W-1:0] ratio_code_t;
endpackage

// File: rtl/clkdiv_rst_sync.sv
`timescale 1ns/1ps
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign rst_ok = stage_q[STAGES-1];
endmodule

// File: rtl/clkdiv_run_cap.sv
`timescale 1ns/1ps
module clkdiv_run_cap (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_ok,
  input  logic run_en,
  output logic run_q
);
  logic run_d;

  always_comb begin
    run_d = run_en & rst_ok;
  end

  // captured on the falling edge so the rising edge sees a settled value
  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) run_q <= 1'b0;
    else         run_q <= run_d;
  end
endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  // down-count: every bit rises on the edge where all lower bits leave zero
  always_comb begin
    cnt_d = cnt_q;
    if (run) cnt_d = cnt_q - {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = run & (cnt_q == '0);
endmodule

// File: rtl/clkdiv_tap_sel.sv
`timescale 1ns/1ps
module clkdiv_tap_sel #(
  parameter int unsigned W       = 4,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned LOW_LOG = 0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wrap,
  input  logic [SEL_W-1:0] sel,
  input  logic [W:0]       taps,
  output logic [SEL_W-1:0] sel_act,
  output logic             clk_out
);
  localparam int unsigned IW = $clog2(W + 1);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic [IW-1:0]    tap_idx;

  always_comb begin
    sel_d = sel_q;
    if (wrap) sel_d = sel;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sel_q <= '0;
    else         sel_q <= sel_d;
  end

  always_comb begin
    tap_idx = IW'(sel_q) + IW'(LOW_LOG);
    clk_out = taps[tap_idx];
  end

  assign sel_act = sel_q;
endmodule

// File: rtl/dual_clkdiv.sv
`timescale 1ns/1ps
module dual_clkdiv
  import clkdiv_pkg::*;
(
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_b,
  output logic       div_a,
  output logic       div_b
);
  logic             rst_ok;
  logic             run_q;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   taps;
  ratio_code_t      sel_a_act;
  ratio_code_t      sel_b_act;
  logic [1:0]       div_vec;

  clkdiv_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk_in), .arst_n(rst_n), .rst_ok(rst_ok)
  );

  clkdiv_run_cap u_run (
    .clk(clk_in), .arst_n(rst_n), .rst_ok(rst_ok), .run_en(run_en), .run_q(run_q)
  );

  clkdiv_counter #(.W(CNT_W)) u_cnt (
    .clk(clk_in), .arst_n(rst_n), .run(run_q), .cnt(cnt), .wrap(wrap)
  );

  // tap 0 is the gated input clock, tap k is a divide by 2^k
  assign taps = {cnt, clk_in & run_q};

  localparam int unsigned NOUT = 2;
  localparam int unsigned LOW_LOG_A = 0;
  localparam int unsigned LOW_LOG_B = 1;

  ratio_code_t sel_in  [NOUT];
  ratio_code_t sel_out [NOUT];
  assign sel_in[0] = sel_a;
  assign sel_in[1] = sel_b;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    clkdiv_tap_sel #(
      .W(CNT_W), .SEL_W(SEL_W), .LOW_LOG(g == 0 ? LOW_LOG_A : LOW_LOG_B)
    ) u_tap (
      .clk(clk_in), .arst_n(rst_n), .wrap(wrap), .sel(sel_in[g]),
      .taps(taps), .sel_act(sel_out[g]), .clk_out(div_vec[g])
    );
  end

  assign sel_a_act = sel_out[0];
  assign sel_b_act = sel_out[1];
  assign div_a     = div_vec[0];
  assign div_b     = div_vec[1];
endmodule

// File: rtl/dual_clkdiv_chk.sv
`timescale 1ns/1ps
module dual_clkdiv_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_in,
  input logic             rst_n,
  input logic             div_a,
  input logic             div_b,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       sel_a_act,
  input logic [1:0]       sel_b_act
);
  // R6
  reset_low_chk: assert property (@(negedge clk_in) !rst_n |-> (!div_a && !div_b));

  // R5
  hold_stable_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !run_q |=> ($stable(div_a) && $stable(div_b) && $stable(cnt)));

  // R8
  sel_wrap_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !(run_q && cnt == '0) |=> ($stable(sel_a_act) && $stable(sel_b_act)));

  // R3
  align_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(div_b) |-> $rose(cnt[0]));

  // R3
  cnt_step_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    run_q |=> (cnt == $past(cnt) - 1'b1));
endmodule

bind dual_clkdiv dual_clkdiv_chk #(.CNT_W(clkdiv_pkg::CNT_W)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .div_a(div_a), .div_b(div_b),
  .run_q(run_q), .cnt(cnt), .sel_a_act(sel_a_act), .sel_b_act(sel_b_act)
);

// File: tb/sim_dual_clkdiv.sv
`timescale 1ns/1ps
module sim_dual_clkdiv;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_en;
  logic [1:0] sel_a, sel_b;
  logic       div_a, div_b;

  always #2.5 clk = ~clk;

  dual_clkdiv u0 (
    .clk_in(clk), .rst_n(rst_n), .run_en(run_en),
    .sel_a(sel_a), .sel_b(sel_b), .div_a(div_a), .div_b(div_b)
  );

  int   nchk = 0;
  int   nfail = 0;
  bit   done = 0;
  int   n_m = 0;
  int   ok_m = 0;
  bit   run_m = 0;
  logic [1:0] sa_act = 0, sb_act = 0;

  function automatic logic div_exp(int ratio, int cnt, bit run);
    if (ratio == 1) return run;
    return (cnt >= 1) && (((cnt - 1) % ratio) < ratio / 2);
  endfunction

  task automatic chk(string tg, string what, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %b expected %b", tg, what, act, exp);
    end
  endtask

  task automatic tick(string tg);
    string ta, tb_;
    logic ea, eb;
    @(posedge clk);
    if (!rst_n) begin
      ok_m = 0; n_m = 0; run_m = 0; sa_act = 0; sb_act = 0;
    end else begin
      run_m = (ok_m >= 2) && run_en;
      if (run_m) begin
        if (n_m % 16 == 0) begin sa_act = sel_a; sb_act = sel_b; end
        n_m++;
      end
      if (ok_m < 2) ok_m++;
    end
    #1;
    if (!rst_n) begin
      ea = 1'b0; eb = 1'b0; ta = "R6"; tb_ = "R6";
    end else begin
      ea = div_exp(1 << sa_act, n_m, run_m);
      eb = div_exp(2 << sb_act, n_m, run_m);
      ta = (sa_act == 0) ? "R4" : "R1";
      tb_ = "R2";
    end
    if (tg != "") begin ta = tg; tb_ = tg; end
    chk(ta, "div_a", div_a, ea);
    chk(tb_, "div_b", div_b, eb);
    if (rst_n && ((1 << sa_act) == (2 << sb_act)))
      chk("R3", "div_a vs div_b", div_a, div_b);
  endtask

  task automatic async_reset();
    rst_n = 1'b0;
    #0.5;
    chk("R6", "div_a async", div_a, 1'b0);
    chk("R6", "div_b async", div_b, 1'b0);
    tick("R6");
    tick("R6");
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20241));
    rst_n = 1'b0; run_en = 1'b0; sel_a = 2'd0; sel_b = 2'd0;
    #1;
    chk("R6", "div_a at reset", div_a, 1'b0);
    chk("R6", "div_b at reset", div_b, 1'b0);
    repeat (3) tick("R6");

    // R7: release with divide by 1 and 2; first rise on the third edge
    run_en = 1'b1;
    rst_n = 1'b1;
    repeat (8) tick("R7");

    // R1 R2: sweep every ratio pair (codes adopted at the wrap)
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        sel_a = 2'(a); sel_b = 2'(b);
        repeat (34) tick("");
      end
    end

    // R5: hold in mid-period, then resume
    sel_a = 2'd1; sel_b = 2'd3;
    repeat (37) tick("");
    run_en = 1'b0;
    repeat (7) tick("R5");
    run_en = 1'b1;
    repeat (12) tick("R5");

    // R8: change codes at phase 5; old ratios hold until the wrap
    while (n_m % 16 != 5) tick("");
    sel_a = 2'd3; sel_b = 2'd0;
    repeat (24) tick("R8");

    // R6 R7: reset in mid-count, then restart with both at divide by 2
    sel_a = 2'd1; sel_b = 2'd0;
    async_reset();
    repeat (6) tick("R7");

    // mixed random stimulus
    for (int i = 0; i < 3000; i++) begin
      int r;
      tick("");
      r = int'($urandom % 1000);
      if (r < 3) begin
        async_reset();
      end else begin
        run_en = (($urandom % 10) < 8);
        if (($urandom % 20) == 0) sel_a = 2'($urandom);
        if (($urandom % 20) == 0) sel_b = 2'($urandom);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule